// File: doc/BRIEF.md
# Serial Memory Status-Write and Write-Protect Controller

This block is the protection logic of a serial-bus (SPI) memory slave. It oversamples the bus pins with the system clock and collects the bits of each chip-select frame. It decodes two commands: a one-byte write-enable command, and a two-byte status-write command. It holds the protect-enable bit and the two block-protect bits in flops. These flops stand in for nonvolatile cells and take a parameter value at reset.

For each array write request, the block compares the 17-bit byte address with the protected region that the block-protect bits select. One cycle later it answers with either a grant or a block. The array is divided into four equal sectors, and the protected region always grows downward from the top of the array.

A hardware lock is formed from the active-low write-protect pin and the protect-enable bit. While the lock is on, only status writes are refused. The array range decode does not change.

Top module: `spi_wp_ctrl`

## Requirements
- R1: The serial data output is never driven: `so_oe` stays 0 at all times.
- R2: After reset, `status` reads 8'h00 and `wel`, `hw_locked`, `arr_grant` and `arr_block` are all 0.
- R3: A frame that carries opcode 8'h06 in exactly 8 SCK rising edges while `cs_n` is low sets `wel` once `cs_n` rises. The same bits in any other number of edges leave `wel` unchanged.
- R4: A frame of exactly 16 edges, with opcode 8'h01 first and then a data byte (both MSB first), updates the status when `wel` is set. Status bit 7 (protect enable) takes data bit 7, status bit 3 takes data bit 3, and status bit 2 takes data bit 2. All other status bits read 0. The same frame clears `wel`.
- R5: A status-write frame that arrives while `wel` is 0 changes nothing.
- R6: A status-write frame of any length other than 16 edges changes neither `status` nor `wel`.
- R7: `hw_locked` is 1 exactly when `wp_n` is 0 and status bit 7 is 1. A complete status write that arrives while the lock is on leaves `status` unchanged and still clears `wel`.
- R8: With `wp_n` at 1, or with status bit 7 at 0, the lock is off and a status write takes effect.
- R9: One cycle after an `arr_req` cycle, exactly one of `arr_grant` and `arr_block` is 1, for that cycle only. The protected range depends on status bits 3:2. With 00, nothing is protected. With 01, addresses 18000h to 1FFFFh are protected. With 10, 10000h to 1FFFFh are protected. With 11, the whole array is protected.
- R10: An array write is granted only if `wel` is 1 and the address is outside the protected range. Otherwise it is blocked.
- R11: The hardware lock does not alter the array range decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock; data is sampled on its rising edge |
| cs_n | input | 1 | Active-low chip select that delimits a frame |
| si | input | 1 | Serial data in |
| so_oe | output | 1 | Output enable of the serial data out; always 0 |
| wp_n | input | 1 | Active-low hardware write-protect pin |
| arr_req | input | 1 | One-cycle array write request |
| arr_addr | input | 17 | Byte address of the array write |
| arr_grant | output | 1 | Array write allowed (one cycle after the request) |
| arr_block | output | 1 | Array write refused (one cycle after the request) |
| status | output | 8 | Status byte as seen by the read path |
| wel | output | 1 | Write-enable latch |
| hw_locked | output | 1 | Hardware status lock is active |

## Verification
A frame counter that slips by one edge turns every valid command into an abort, so `wel` and `status` stay frozen after the very first frame. A wrong bit alignment in the shift register shows up as a wrong status byte, a few system clocks after `cs_n` rises. A wrong region boundary shows up at the first request on either side of 10000h or 18000h, one cycle after `arr_req`. A lock that is computed wrongly shows up either as a status change while `hw_locked` is high or as a refused write while it is low.

// File: rtl/spi_wp_pkg.sv
// Shared constants and types of the serial-memory write-protect controller.
// Assumes a status layout with protect enable at bit 7 and block protect at 3:2.
package spi_wp_pkg;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRSR = 8'h01;

    localparam int FRAME_CMD_BITS = 8;
    localparam int FRAME_WR_BITS  = 16;

    localparam int ST_WPEN = 7;
    localparam int ST_BP_HI = 3;
    localparam int ST_BP_LO = 2;

    typedef struct packed {
        logic       wpen;
        logic [1:0] bp;
    } nv_bits_t;

endpackage

// File: rtl/spi_wp_frame_rx.sv
// Frame receiver: synchronises cs_n/sck/si into clk, counts SCK rising edges
// while selected, shifts in SI MSB-first and, when cs_n rises, presents the
// edge count and the last SHIFT_W bits for one cycle.
// Assumes SCK is slow enough that each level lasts at least two clk cycles.
module spi_wp_frame_rx #(
    parameter int SYNC_STAGES = 2,
    parameter int SHIFT_W     = 16,
    parameter int CNT_W       = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck,
    input  logic               cs_n,
    input  logic               si,
    output logic               frame_done,
    output logic [CNT_W-1:0]   frame_bits,
    output logic [SHIFT_W-1:0] frame_data
);

    localparam int NPIN = 3;
    localparam logic [NPIN-1:0] PIN_IDLE = 3'b100; // cs_n high, sck low, si low
    localparam logic [CNT_W-1:0] CNT_SAT = '1;

    logic [NPIN-1:0] pins_raw;
    logic [NPIN-1:0] stage_q [SYNC_STAGES];
    logic [NPIN-1:0] pins_s;
    logic            cs_d, sck_d;
    logic            cs_s, sck_s, si_s;
    logic            sck_rise, cs_rise, cs_fall;
    logic [CNT_W-1:0]   cnt_q;
    logic [SHIFT_W-1:0] sh_q;

    assign pins_raw = {cs_n, sck, si};

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                // first synchroniser stage samples the pins
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= PIN_IDLE;
                    else        stage_q[g] <= pins_raw;
                end
            end else begin : g_next
                // later stages resolve metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= PIN_IDLE;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign pins_s = stage_q[SYNC_STAGES-1];
    assign cs_s   = pins_s[2];
    assign sck_s  = pins_s[1];
    assign si_s   = pins_s[0];

    // previous synchronised levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d  <= 1'b1;
            sck_d <= 1'b0;
        end else begin
            cs_d  <= cs_s;
            sck_d <= sck_s;
        end
    end

    assign sck_rise = sck_s & ~sck_d & ~cs_s;
    assign cs_rise  = cs_s & ~cs_d;
    assign cs_fall  = ~cs_s & cs_d;

    // edge counter, saturating so long frames never wrap into a valid length
    always_ff @(posedge clk) begin
        if (!rst_n)                            cnt_q <= '0;
        else if (cs_fall)                      cnt_q <= '0;
        else if (sck_rise && cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
    end

    // serial-in shift register, MSB first
    always_ff @(posedge clk) begin
        if (!rst_n)        sh_q <= '0;
        else if (sck_rise) sh_q <= {sh_q[SHIFT_W-2:0], si_s};
    end

    // frame result, presented for one cycle after deselect
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_done <= 1'b0;
            frame_bits <= '0;
            frame_data <= '0;
        end else begin
            frame_done <= cs_rise;
            if (cs_rise) begin
                frame_bits <= cnt_q;
                frame_data <= sh_q;
            end
        end
    end

endmodule

// File: rtl/spi_wp_status.sv
// Status register and write-enable latch. Decodes completed frames, applies
// status writes unless the hardware lock (wp_n low and protect enable set)
// is on, and clears the latch after each complete status write.
// Assumes frame_done is a one-cycle pulse with frame_bits/frame_data valid.
module spi_wp_status
    import spi_wp_pkg::*;
#(
    parameter int       SYNC_STAGES = 2,
    parameter int       SHIFT_W     = 16,
    parameter int       CNT_W       = 5,
    parameter nv_bits_t NV_RST      = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wp_n,
    input  logic               frame_done,
    input  logic [CNT_W-1:0]   frame_bits,
    input  logic [SHIFT_W-1:0] frame_data,
    output logic [7:0]         status,
    output logic               wel,
    output logic               hw_locked
);

    localparam logic [CNT_W-1:0] LEN_CMD = CNT_W'(FRAME_CMD_BITS);
    localparam logic [CNT_W-1:0] LEN_WR  = CNT_W'(FRAME_WR_BITS);

    logic [SYNC_STAGES-1:0] wp_sync;
    nv_bits_t               nv_q;
    logic                   is_wren, is_wrsr;

    // synchronise the write-protect pin
    always_ff @(posedge clk) begin
        if (!rst_n) wp_sync <= '1;
        else        wp_sync <= {wp_sync[SYNC_STAGES-2:0], wp_n};
    end

    assign hw_locked = nv_q.wpen & ~wp_sync[SYNC_STAGES-1];

    assign is_wren = frame_done && frame_bits == LEN_CMD && frame_data[7:0] == OP_WREN;
    assign is_wrsr = frame_done && frame_bits == LEN_WR  && frame_data[15:8] == OP_WRSR;

    // write-enable latch: set by write-enable, cleared by any complete status write
    always_ff @(posedge clk) begin
        if (!rst_n)              wel <= 1'b0;
        else if (is_wrsr && wel) wel <= 1'b0;
        else if (is_wren)        wel <= 1'b1;
    end

    // nonvolatile status bits, frozen while the hardware lock is on
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nv_q <= NV_RST;
        end else if (is_wrsr && wel && !hw_locked) begin
            nv_q.wpen <= frame_data[ST_WPEN];
            nv_q.bp   <= frame_data[ST_BP_HI:ST_BP_LO];
        end
    end

    // place the held bits into the status byte; unused bits read zero
    always_comb begin
        status                   = '0;
        status[ST_WPEN]          = nv_q.wpen;
        status[ST_BP_HI:ST_BP_LO] = nv_q.bp;
    end

endmodule

// File: rtl/spi_wp_range.sv
// Array write range check. The array is four equal sectors; the protect
// level selects a region that grows down from the top address. Answers each
// request with a one-cycle grant or block in the following cycle.
// Assumes ADDR_W >= 3.
module spi_wp_range #(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        bp,
    input  logic              wel,
    output logic              grant,
    output logic              block
);

    localparam logic [ADDR_W:0] B_NONE = {1'b1, {ADDR_W{1'b0}}};
    localparam logic [ADDR_W:0] B_QTR  = {3'b011, {(ADDR_W-2){1'b0}}};
    localparam logic [ADDR_W:0] B_HALF = {2'b01, {(ADDR_W-1){1'b0}}};
    localparam logic [ADDR_W:0] B_ALL  = '0;

    logic [ADDR_W:0] bound;
    logic            in_prot, ok;

    // lowest protected address for the selected level
    always_comb begin
        case (bp)
            2'b00:   bound = B_NONE;
            2'b01:   bound = B_QTR;
            2'b10:   bound = B_HALF;
            default: bound = B_ALL;
        endcase
    end

    assign in_prot = {1'b0, addr} >= bound;
    assign ok      = wel & ~in_prot;

    // registered one-cycle answer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant <= 1'b0;
            block <= 1'b0;
        end else begin
            grant <= req & ok;
            block <= req & ~ok;
        end
    end

endmodule

// File: rtl/spi_wp_ctrl.sv
// Top of the serial-memory write-protect controller: frame receiver,
// status register with hardware lock, and array range check.
// Assumes the system clock runs at least four times faster than SCK.
module spi_wp_ctrl
    import spi_wp_pkg::*;
#(
    parameter int       ADDR_W      = 17,
    parameter int       SYNC_STAGES = 2,
    parameter nv_bits_t NV_RST      = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    output logic              so_oe,
    input  logic              wp_n,
    input  logic              arr_req,
    input  logic [ADDR_W-1:0] arr_addr,
    output logic              arr_grant,
    output logic              arr_block,
    output logic [7:0]        status,
    output logic              wel,
    output logic              hw_locked
);

    localparam int SHIFT_W = FRAME_WR_BITS;
    localparam int CNT_W   = $clog2(FRAME_WR_BITS + 1);

    logic               frame_done;
    logic [CNT_W-1:0]   frame_bits;
    logic [SHIFT_W-1:0] frame_data;

    // this block only accepts writes; the output pin stays released
    assign so_oe = 1'b0;

    spi_wp_frame_rx #(
        .SYNC_STAGES (SYNC_STAGES),
        .SHIFT_W     (SHIFT_W),
        .CNT_W       (CNT_W)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck        (sck),
        .cs_n       (cs_n),
        .si         (si),
        .frame_done (frame_done),
        .frame_bits (frame_bits),
        .frame_data (frame_data)
    );

    spi_wp_status #(
        .SYNC_STAGES (SYNC_STAGES),
        .SHIFT_W     (SHIFT_W),
        .CNT_W       (CNT_W),
        .NV_RST      (NV_RST)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .wp_n       (wp_n),
        .frame_done (frame_done),
        .frame_bits (frame_bits),
        .frame_data (frame_data),
        .status     (status),
        .wel        (wel),
        .hw_locked  (hw_locked)
    );

    spi_wp_range #(
        .ADDR_W (ADDR_W)
    ) u_range (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (arr_req),
        .addr  (arr_addr),
        .bp    (status[ST_BP_HI:ST_BP_LO]),
        .wel   (wel),
        .grant (arr_grant),
        .block (arr_block)
    );

endmodule

// File: rtl/spi_wp_ctrl_sva.sv
// Checker for spi_wp_ctrl: protocol properties on its ports.
module spi_wp_ctrl_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       arr_req,
    input logic       arr_grant,
    input logic       arr_block,
    input logic [7:0] status,
    input logic       wel,
    input logic       hw_locked
);

    AST_ANSWER_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_grant || arr_block) |-> $past(arr_req)); // R9

    AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        $past(arr_req) |-> $countones({arr_grant, arr_block}) == 1); // R9

    AST_FULL_LEVEL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(arr_req) && $past(status[3:2]) == 2'b11) |-> arr_block); // R9

    AST_GRANT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        arr_grant |-> $past(wel)); // R10

    AST_NO_WEL_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wel) |-> $stable(status)); // R5

    AST_UPDATE_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status) |-> !wel); // R4

    AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hw_locked) |-> $stable(status)); // R7

endmodule

bind spi_wp_ctrl spi_wp_ctrl_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .arr_req   (arr_req),
    .arr_grant (arr_grant),
    .arr_block (arr_block),
    .status    (status),
    .wel       (wel),
    .hw_locked (hw_locked)
);

// File: tb/spi_wp_ctrl_test.sv
module spi_wp_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        cs_n = 1'b1;
    logic        si = 1'b0;
    logic        wp_n = 1'b1;
    logic        arr_req = 1'b0;
    logic [16:0] arr_addr = '0;
    logic        so_oe, arr_grant, arr_block, wel, hw_locked;
    logic [7:0]  status;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    spi_wp_ctrl uut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .so_oe(so_oe), .wp_n(wp_n), .arr_req(arr_req), .arr_addr(arr_addr),
        .arr_grant(arr_grant), .arr_block(arr_block), .status(status),
        .wel(wel), .hw_locked(hw_locked)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // shift the low n bits of v, MSB first, in one chip-select frame
    task automatic frame(input logic [31:0] v, input int n);
        @(negedge clk);
        cs_n = 1'b0;
        waitc(4);
        for (int i = n - 1; i >= 0; i--) begin
            si = v[i];
            waitc(4);
            sck = 1'b1;
            waitc(4);
            sck = 1'b0;
        end
        waitc(4);
        cs_n = 1'b1;
        waitc(8);
    endtask

    task automatic set_wel();
        frame(32'h06, 8);
    endtask

    task automatic write_status(input logic [7:0] d);
        set_wel();
        frame({16'h0, 8'h01, d}, 16);
    endtask

    // one-cycle request; answer sampled one negedge later
    task automatic probe(input string req, input logic [16:0] a, input logic exp_grant);
        @(negedge clk);
        arr_req = 1'b1;
        arr_addr = a;
        @(negedge clk);
        arr_req = 1'b0;
        chk(req, {30'h0, arr_grant, arr_block}, {30'h0, exp_grant, ~exp_grant});
        @(negedge clk);
        chk(req, {30'h0, arr_grant, arr_block}, 32'h0);
    endtask

    task automatic t_reset();
        chk("R2", status, 8'h00);
        chk("R2", wel, 1'b0);
        chk("R2", hw_locked, 1'b0);
        chk("R2", {arr_grant, arr_block}, 2'b00);
        chk("R1", so_oe, 1'b0);
    endtask

    task automatic t_no_wel();
        frame({16'h0, 8'h01, 8'hFF}, 16);
        chk("R5", status, 8'h00);
        chk("R5", wel, 1'b0);
    endtask

    task automatic t_wren_len();
        frame(32'h03, 7);
        chk("R3", wel, 1'b0);
        frame(32'h0C, 9);
        chk("R3", wel, 1'b0);
        set_wel();
        chk("R3", wel, 1'b1);
    endtask

    task automatic t_abort();
        frame({17'h0, 8'h01, 7'h06}, 15);
        chk("R6", status, 8'h00);
        chk("R6", wel, 1'b1);
        frame({15'h0, 8'h01, 8'h0C, 1'b0}, 17);
        chk("R6", status, 8'h00);
        chk("R6", wel, 1'b1);
    endtask

    task automatic t_write();
        frame({16'h0, 8'h01, 8'hFF}, 16);
        chk("R4", status, 8'h8C);
        chk("R4", wel, 1'b0);
        chk("R1", so_oe, 1'b0);
    endtask

    task automatic t_ranges();
        write_status(8'h04);
        chk("R4", status, 8'h04);
        set_wel();
        probe("R9", 17'h17FFF, 1'b1);
        probe("R9", 17'h18000, 1'b0);
        probe("R9", 17'h1FFFF, 1'b0);
        write_status(8'h08);
        set_wel();
        probe("R9", 17'h0FFFF, 1'b1);
        probe("R9", 17'h10000, 1'b0);
        write_status(8'h0C);
        set_wel();
        probe("R9", 17'h00000, 1'b0);
        write_status(8'h00);
        set_wel();
        probe("R9", 17'h1FFFF, 1'b1);
        probe("R9", 17'h00000, 1'b1);
        frame({16'h0, 8'h01, 8'h00}, 16);
        chk("R10", wel, 1'b0);
        probe("R10", 17'h00000, 1'b0);
    endtask

    task automatic t_lock();
        wp_n = 1'b0;
        waitc(4);
        chk("R8", hw_locked, 1'b0);
        write_status(8'h88);
        chk("R8", status, 8'h88);
        chk("R7", hw_locked, 1'b1);
        write_status(8'h00);
        chk("R7", status, 8'h88);
        chk("R7", wel, 1'b0);
        set_wel();
        probe("R11", 17'h0FFFF, 1'b1);
        probe("R11", 17'h10000, 1'b0);
        wp_n = 1'b1;
        waitc(4);
        chk("R8", hw_locked, 1'b0);
        write_status(8'h00);
        chk("R8", status, 8'h00);
    endtask

    initial begin
        waitc(5);
        rst_n = 1'b1;
        waitc(2);
        t_reset();
        t_no_wel();
        t_wren_len();
        t_abort();
        t_write();
        t_ranges();
        t_lock();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule